// File: doc/BRIEF.md
# Programmable Supervisory Watchdog

This block watches a processor through a timer that software arms by writing one 8-bit control register. The register packs a steering bit, a 5-bit count multiplier and a 2-bit resolution code. The timeout is the multiplier times the selected resolution, measured in pulses of a 1/16-second time base. Software keeps the timer from expiring in one of two ways: it rewrites the register, or it toggles an external kick pin in either direction. Either action restarts the interval from zero.

When the interval runs out, the block sets a sticky watchdog flag. Reading the flag register clears it. The steering bit picks the action on expiry. With steering clear, the block raises an interrupt line. With steering set, it drives an active-low reset output for a fixed number of clocks. In the last cycle of that pulse it clears the control register and gives neighbouring logic a one-cycle strobe, so they can drop their frequency-test, alarm-flag-enable and alarm-battery-enable bits.

A multiplier of zero disables the timer. After one expiry the timer stays quiet until the next restart.

Top module: `wdog_supervisor`

## Requirements
- R1: Register bits 6:2 hold the multiplier M and bits 1:0 the resolution code r. The resolution is 1, 4, 16 or 64 time-base pulses for r = 0, 1, 2, 3. Counted from a restart, expiry occurs on time-base pulse number M × 4^r. This is exactly the pulse count for 1/16 s, 1/4 s, 1 s and 4 s per step.
- R2: When M is zero, no expiry occurs, whatever the number of time-base pulses.
- R3: On expiry, `wd_flag` reads 1 from the following clock. A one-cycle `flag_rd` strobe returns it to 0.
- R4: When bit 7 of the register is 0, expiry sets `irq` to 1. `irq` stays at 1 until `flag_rd` clears it, and `rst_out_n` stays at 1.
- R5: When bit 7 is 1, `rst_out_n` is 0 for exactly RST_CYCLES clocks, starting the clock after expiry. `irq` stays at 0.
- R6: In the last low cycle of that reset pulse, `ctrl_clr` is 1 for exactly one clock. After the pulse, `cfg_rdata` reads 0x00.
- R7: A register write restarts the interval. It also clears the resolution prescaler, so time-base pulses seen before the write do not count.
- R8: A rising or a falling edge on `kick_in` restarts the interval. The edge is detected after a two-flop synchroniser.
- R9: After an expiry, no further expiry occurs until the next restart.
- R10: After reset, `wd_flag` and `irq` are 0, `rst_out_n` is 1 and `cfg_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16 | input | 1 | One-clock pulse every 1/16 s |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Write data: bit 7 steering, 6:2 multiplier, 1:0 resolution |
| cfg_rdata | output | 8 | Current control register value |
| kick_in | input | 1 | Asynchronous kick pin, either edge restarts |
| flag_rd | input | 1 | Flag register read strobe, clears the flag |
| wd_flag | output | 1 | Sticky watchdog-expired flag |
| irq | output | 1 | Interrupt request for interrupt-steered expiry |
| rst_out_n | output | 1 | Active-low reset pulse for reset-steered expiry |
| ctrl_clr | output | 1 | One-cycle strobe clearing neighbouring control bits |

## Verification
The hardest case to reach is an expiry that must land exactly on pulse M × 4^r for every resolution. At 4 s per step, that means thousands of time-base pulses. The bench therefore drives the time base as fast as one pulse every two clocks, and sweeps every multiplier at the three finer resolutions plus several at the coarsest. It checks that the flag is still clear one pulse before the boundary and set on it. A restart is also placed in the middle of a partial prescaler period, which shows whether the prescaler was really cleared.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic {
      STEER_IRQ = 1'b0,
      STEER_RST = 1'b1
   } steer_e;

   // terminal prescaler value for resolution code sel: ratio 2^(sel*shift), minus one
   function automatic int unsigned stage_limit(input int unsigned sel, input int unsigned shift);
      return (32'd1 << (sel * shift)) - 32'd1;
   endfunction

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic edge_o
);
   localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("wdog_kick_sync: SYNC_STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;

   for (genvar s = 0; s < CHAIN_W; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= kick_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   // any change between the last synchronised stage and its delayed copy
   assign edge_o = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
   parameter int unsigned RES_W     = 2,
   parameter int unsigned RES_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [RES_W-1:0] sel_i,
   output logic             unit_o
);
   localparam int unsigned NUM_RES = 1 << RES_W;
   localparam int unsigned PRE_W   = (RES_SHIFT * (NUM_RES - 1) > 0) ? RES_SHIFT * (NUM_RES - 1) : 1;

   if (RES_W < 1) begin : g_bad_res
      $error("wdog_timebase: RES_W must be at least 1");
   end
   if (RES_SHIFT < 1) begin : g_bad_shift
      $error("wdog_timebase: RES_SHIFT must be at least 1");
   end

   logic [PRE_W-1:0]   pre_q;
   logic [NUM_RES-1:0] at_limit;
   logic               last;

   for (genvar g = 0; g < NUM_RES; g++) begin : g_limit
      localparam int unsigned LIM = wdog_pkg::stage_limit(g, RES_SHIFT);
      localparam logic [PRE_W-1:0] LIM_V = LIM[PRE_W-1:0];
      assign at_limit[g] = (pre_q == LIM_V);
   end

   assign last   = at_limit[sel_i];
   assign unit_o = tick_i & last & ~restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (restart_i) begin
         pre_q <= '0;
      end else if (tick_i) begin
         pre_q <= last ? '0 : pre_q + 1'b1;
      end
   end

   // R7: a restart leaves the prescaler at zero
   assert_pre_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (pre_q == '0));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned MULT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_i,
   input  logic              restart_i,
   input  logic [MULT_W-1:0] mult_i,
   output logic              expire_o
);
   localparam int unsigned CMP_W = MULT_W + 1;

   if (MULT_W < 1) begin : g_bad_mult
      $error("wdog_counter: MULT_W must be at least 1");
   end

   logic [MULT_W-1:0] cnt_q;
   logic              armed_q;
   logic [CMP_W-1:0]  next_cnt;
   logic              enabled;

   assign next_cnt = {1'b0, cnt_q} + 1'b1;
   assign enabled  = (mult_i != '0);
   assign expire_o = unit_i & armed_q & enabled & (next_cnt == {1'b0, mult_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (restart_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (expire_o) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (unit_i && armed_q) begin
         cnt_q   <= next_cnt[MULT_W-1:0];
      end
   end

   // R9: one expiry disarms the timer until the next restart
   assert_one_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !restart_i) |=> !armed_q);

endmodule

// File: rtl/wdog_reset_pulse.sv
module wdog_reset_pulse #(
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic rst_n_o,
   output logic done_o
);
   localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RST_CYCLES);

   if (RST_CYCLES < 1) begin : g_bad_len
      $error("wdog_reset_pulse: RST_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= LOAD_V;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign rst_n_o = (cnt_q == '0);
   assign done_o  = (cnt_q == CNT_W'(1));

   // R5: the pulse begins on the clock after the start request
   assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !rst_n_o);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
   parameter int unsigned MULT_W      = 5,
   parameter int unsigned RES_W       = 2,
   parameter int unsigned RES_SHIFT   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_CYCLES  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick_16,
   input  logic                         cfg_we,
   input  logic [MULT_W+RES_W:0]        cfg_wdata,
   output logic [MULT_W+RES_W:0]        cfg_rdata,
   input  logic                         kick_in,
   input  logic                         flag_rd,
   output logic                         wd_flag,
   output logic                         irq,
   output logic                         rst_out_n,
   output logic                         ctrl_clr
);
   import wdog_pkg::*;

   localparam int unsigned REG_W   = 1 + MULT_W + RES_W;
   localparam int unsigned STEER_B = REG_W - 1;
   localparam int unsigned MULT_LO = RES_W;
   localparam int unsigned MULT_HI = RES_W + MULT_W - 1;

   logic [REG_W-1:0]  cfg_q;
   logic [MULT_W-1:0] mult;
   logic [RES_W-1:0]  res_sel;
   steer_e            steer;
   logic              kick_edge;
   logic              restart;
   logic              unit_tick;
   logic              expire;
   logic              pulse_done;
   logic              flag_q;
   logic              irq_q;

   assign mult    = cfg_q[MULT_HI:MULT_LO];
   assign res_sel = cfg_q[RES_W-1:0];
   assign steer   = steer_e'(cfg_q[STEER_B]);
   assign restart = cfg_we | kick_edge;

   wdog_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_kick (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick_i (kick_in),
      .edge_o (kick_edge)
   );

   wdog_timebase #(.RES_W(RES_W), .RES_SHIFT(RES_SHIFT)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_16),
      .restart_i (restart),
      .sel_i     (res_sel),
      .unit_o    (unit_tick)
   );

   wdog_counter #(.MULT_W(MULT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .unit_i    (unit_tick),
      .restart_i (restart),
      .mult_i    (mult),
      .expire_o  (expire)
   );

   wdog_reset_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (expire && steer == STEER_RST),
      .rst_n_o (rst_out_n),
      .done_o  (pulse_done)
   );

   // control register: the end of a reset pulse wins over a write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_q <= '0;
      else if (pulse_done) cfg_q <= '0;
      else if (cfg_we)     cfg_q <= cfg_wdata;
   end

   // sticky flag and interrupt; a fresh expiry wins over a read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (expire)       flag_q <= 1'b1;
         else if (flag_rd) flag_q <= 1'b0;

         if (expire && steer == STEER_IRQ) irq_q <= 1'b1;
         else if (flag_rd)                 irq_q <= 1'b0;
      end
   end

   assign cfg_rdata = cfg_q;
   assign wd_flag   = flag_q;
   assign irq       = irq_q;
   assign ctrl_clr  = pulse_done;

   assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> wd_flag);

   assert_irq_steer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && steer == STEER_IRQ) |=> (irq && rst_out_n));

   assert_zero_mult_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mult == '0) |-> !expire);

   assert_reg_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> (cfg_q == '0));

endmodule

// File: tb/test_wdog_supervisor.sv
`timescale 1ns/1ps
module test_wdog_supervisor;

   localparam int unsigned RST_LEN = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_16 = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       kick_in = 1'b0;
   logic       flag_rd = 1'b0;
   logic       wd_flag;
   logic       irq;
   logic       rst_out_n;
   logic       ctrl_clr;

   int unsigned n_vec  = 0;
   int unsigned n_fail = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   wdog_supervisor #(.RST_CYCLES(RST_LEN)) i_wdog_supervisor (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_16   (tick_16),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .kick_in   (kick_in),
      .flag_rd   (flag_rd),
      .wd_flag   (wd_flag),
      .irq       (irq),
      .rst_out_n (rst_out_n),
      .ctrl_clr  (ctrl_clr)
   );

   task automatic chk(input string req, input int actual, input int expected);
      n_vec++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_16 = 1'b1;
         @(negedge clk) tick_16 = 1'b0;
      end
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = v; end
      @(negedge clk) cfg_we = 1'b0;
   endtask

   task automatic rd_flag();
      @(negedge clk) flag_rd = 1'b1;
      @(negedge clk) flag_rd = 1'b0;
   endtask

   task automatic kick_toggle();
      @(negedge clk) kick_in = ~kick_in;
      repeat (5) @(negedge clk);
   endtask

   function automatic logic [7:0] cfg(input bit st, input int m, input int r);
      return {st, 5'(m), 2'(r)};
   endfunction

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 flag", wd_flag, 0);
      chk("R10 irq", irq, 0);
      chk("R10 rst_out_n", rst_out_n, 1);
      chk("R10 cfg_rdata", cfg_rdata, 0);

      // R1/R3/R4 sweep: every multiplier at r=0..2, selected ones at r=3
      for (int r = 0; r < 4; r++) begin
         for (int m = 1; m < 32; m++) begin
            int n;
            if (r == 3 && !(m == 1 || m == 2 || m == 3 || m == 31)) continue;
            n = m * (1 << (2 * r));
            wr(cfg(1'b0, m, r));
            ticks(n - 1);
            chk($sformatf("R1 early m=%0d r=%0d", m, r), wd_flag, 0);
            ticks(1);
            chk($sformatf("R1 due m=%0d r=%0d", m, r), wd_flag, 1);
            chk("R4 irq", irq, 1);
            chk("R4 rst_out_n", rst_out_n, 1);
            rd_flag();
            chk("R3 flag cleared", wd_flag, 0);
            chk("R4 irq cleared", irq, 0);
         end
      end

      // R9 one-shot
      wr(cfg(1'b0, 2, 0));
      ticks(2);
      chk("R9 first expiry", wd_flag, 1);
      rd_flag();
      ticks(10);
      chk("R9 no second flag", wd_flag, 0);
      chk("R9 no second irq", irq, 0);

      // R7 rewrite restarts and clears prescaler (r=1, m=1 -> 4 pulses)
      wr(cfg(1'b0, 1, 1));
      ticks(3);
      wr(cfg(1'b0, 1, 1));
      ticks(3);
      chk("R7 not yet", wd_flag, 0);
      ticks(1);
      chk("R7 due", wd_flag, 1);
      rd_flag();

      // R8 rising then falling kick edge
      wr(cfg(1'b0, 3, 0));
      ticks(2);
      kick_toggle();
      ticks(2);
      chk("R8 rise not yet", wd_flag, 0);
      ticks(1);
      chk("R8 rise due", wd_flag, 1);
      rd_flag();
      wr(cfg(1'b0, 3, 0));
      ticks(2);
      kick_toggle();
      ticks(2);
      chk("R8 fall not yet", wd_flag, 0);
      ticks(1);
      chk("R8 fall due", wd_flag, 1);
      rd_flag();

      // R2 zero multiplier disables
      wr(8'h83);
      ticks(200);
      chk("R2 flag", wd_flag, 0);
      chk("R2 rst_out_n", rst_out_n, 1);
      wr(8'h00);
      ticks(20);
      chk("R2 flag r0", wd_flag, 0);

      // R5/R6 reset-steered expiry
      wr(cfg(1'b1, 2, 0));
      chk("R6 cfg written", cfg_rdata, 8'h88);
      ticks(1);
      chk("R5 early", wd_flag, 0);
      ticks(1);
      chk("R3 flag reset mode", wd_flag, 1);
      begin
         int low_cnt = 0;
         int clr_cnt = 0;
         while (rst_out_n == 1'b0 && low_cnt < 100) begin
            if (ctrl_clr) clr_cnt++;
            low_cnt++;
            @(negedge clk);
         end
         chk("R5 pulse length", low_cnt, RST_LEN);
         chk("R6 ctrl_clr count", clr_cnt, 1);
      end
      chk("R6 cfg cleared", cfg_rdata, 0);
      chk("R5 irq quiet", irq, 0);
      chk("R6 ctrl_clr idle", ctrl_clr, 0);
      rd_flag();
      chk("R3 flag cleared", wd_flag, 0);

      report();
   end

endmodule